// File: doc/BRIEF.md
# Row Address Pointer Controller

This block tracks which row of a row-addressed mirror array receives the next line of pixel data. Rows are written in row cycles of a fixed number of valid clocks, and a cycle starts on the first clock that the data-valid strobe is high. On that first clock the block reads a 2-bit row command and an address field. It updates an internal logical row pointer and reports the physical row to write. It then ignores the command inputs until the cycle's remaining valid clocks have gone by. Clocks with data-valid low pause the cycle and do not end it.

Two quasi-static controls shape the command. The orientation flag makes the step command walk downward, and it makes the home command jump to the last row instead of row 0. Quad mode groups four physical rows under each logical address, which cuts the addressable range to a quarter. The pointer never wraps. A step that would leave the array, or a direct load beyond it, is refused: the pointer stays put, no write strobe is issued, and a sticky range-error flag is raised. The flag clears only on reset.

Top module: `rowAddrCtrl`

## Requirements
- R1: While reset is asserted and right after it, physRow is 0, repCount is 1, writeStb is 0 and rangeErr is 0, and the logical pointer is 0.
- R2: A row cycle spans CLKS clocks that have dataValid high. rowMode and rowAddr are read only on the first of them. writeStb is high for exactly the one clock after that first valid clock, and it stays low for the rest of the cycle, whatever the command inputs do.
- R3: Clocks with dataValid low do not advance the row cycle. After a pause the cycle resumes, and no new command is read until all CLKS valid clocks have occurred.
- R4: Command code 00 (idle) leaves the pointer unchanged and issues no write.
- R5: Command code 01 (step) with flipEn=0 raises the pointer by one and writes that row.
- R6: Command code 01 with flipEn=1 lowers the pointer by one and writes that row.
- R7: Command code 10 (load) sets the pointer to rowAddr and writes it, whatever flipEn is. A rowAddr above the last logical row is refused: the pointer is unchanged, there is no write, and rangeErr is set.
- R8: Command code 11 (home) sets the pointer to 0 when flipEn=0, or to the last logical row when flipEn=1, and writes it.
- R9: A step up from the last logical row, or a step down from row 0 or from a pointer above the last logical row, leaves the pointer unchanged, issues no write and sets rangeErr. The pointer never wraps.
- R10: rangeErr stays high once set, until reset.
- R11: With quadEn=1, the last logical row is ROWS/4-1. A write reports physRow = 4 × pointer and repCount = 4, and step moves the logical pointer by exactly one. With quadEn=0, repCount = 1 and physRow equals the pointer.
- R12: physRow and repCount change only on a write, and they hold their values while dataValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataValid | input | 1 | Frames the valid clocks of a row cycle |
| rowMode | input | 2 | Row command: 00 idle, 01 step, 10 load, 11 home |
| rowAddr | input | ADDR_W | Logical row for the load command |
| flipEn | input | 1 | Reverses the step direction and the home target |
| quadEn | input | 1 | Four physical rows per logical address |
| physRow | output | ROW_W | First physical row of the latest write |
| repCount | output | 3 | Physical rows covered by the latest write (1 or 4) |
| writeStb | output | 1 | One-clock pulse for each accepted row write |
| rangeErr | output | 1 | Sticky flag for a refused step or load |

## Verification
The bench builds the block with ROWS=64 and CLKS=4 rather than the defaults of 1600 and 20. The shorter array lets random step runs reach both ends in a few dozen rows, so non-wrap refusals happen often and not only in directed cases. The short cycle keeps each row cheap while still leaving room for mid-cycle pauses and garbage on the command inputs. The quad range of 16 logical rows is small enough for random loads to fall on both sides of its limit.

// File: rtl/rowPtrPkg.sv
package rowPtrPkg;

  typedef enum logic [1:0] {
    RM_IDLE = 2'b00,
    RM_STEP = 2'b01,
    RM_LOAD = 2'b10,
    RM_HOME = 2'b11
  } rowMode_e;

  typedef struct packed {
    logic rowStart;
  } seqStrobe_t;

  localparam int REP_W = 3;

endpackage

// File: rtl/rowCycleSeq.sv
module rowCycleSeq
  import rowPtrPkg::*;
#(
  parameter int CLKS = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataValid,
  output seqStrobe_t strobe
);

  localparam int PH_W = (CLKS > 1) ? $clog2(CLKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (dataValid) begin
      if (phase == PH_LAST) phase <= '0;
      else                  phase <= phase + 1'b1;
    end
  end

  always_comb begin
    strobe.rowStart = dataValid && (phase == '0);
  end

endmodule

// File: rtl/rowStepCalc.sv
module rowStepCalc
  import rowPtrPkg::*;
#(
  parameter int ROWS   = 1600,
  parameter int ADDR_W = 11,
  parameter int ROW_W  = $clog2(ROWS)
) (
  input  logic [ROW_W-1:0]  curPtr,
  input  rowMode_e          mode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              flipEn,
  input  logic              quadEn,
  output logic [ROW_W-1:0]  nextPtr,
  output logic              doWrite,
  output logic              outOfRange
);

  localparam logic [ROW_W-1:0] LAST_FULL = ROW_W'(ROWS - 1);
  localparam logic [ROW_W-1:0] LAST_QUAD = ROW_W'(ROWS / 4 - 1);

  logic [ROW_W-1:0]  lastRow;
  logic [ADDR_W-1:0] lastWide;

  always_comb begin
    lastRow  = quadEn ? LAST_QUAD : LAST_FULL;
    lastWide = ADDR_W'(lastRow);
  end

  always_comb begin
    nextPtr    = curPtr;
    doWrite    = 1'b0;
    outOfRange = 1'b0;
    case (mode)
      RM_STEP: begin
        if (flipEn) begin
          if (curPtr == '0 || curPtr > lastRow) begin
            outOfRange = 1'b1;
          end else begin
            nextPtr = curPtr - 1'b1;
            doWrite = 1'b1;
          end
        end else begin
          if (curPtr >= lastRow) begin
            outOfRange = 1'b1;
          end else begin
            nextPtr = curPtr + 1'b1;
            doWrite = 1'b1;
          end
        end
      end
      RM_LOAD: begin
        if (addrIn > lastWide) begin
          outOfRange = 1'b1;
        end else begin
          nextPtr = addrIn[ROW_W-1:0];
          doWrite = 1'b1;
        end
      end
      RM_HOME: begin
        nextPtr = flipEn ? lastRow : '0;
        doWrite = 1'b1;
      end
      default: begin
        nextPtr = curPtr;
      end
    endcase
  end

endmodule

// File: rtl/rowPtrPath.sv
module rowPtrPath
  import rowPtrPkg::*;
#(
  parameter int ROWS   = 1600,
  parameter int ADDR_W = 11,
  parameter int ROW_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [1:0]        rowMode,
  input  logic [ADDR_W-1:0] rowAddr,
  input  logic              flipEn,
  input  logic              quadEn,
  output logic [ROW_W-1:0]  physRow,
  output logic [REP_W-1:0]  repCount,
  output logic              writeStb,
  output logic              rangeErr
);

  logic [ROW_W-1:0] ptr;
  logic [ROW_W-1:0] nextPtr;
  logic             doWrite;
  logic             outOfRange;
  logic [ROW_W-1:0] nextPhys;

  rowStepCalc #(
    .ROWS  (ROWS),
    .ADDR_W(ADDR_W),
    .ROW_W (ROW_W)
  ) stepCalc (
    .curPtr    (ptr),
    .mode      (rowMode_e'(rowMode)),
    .addrIn    (rowAddr),
    .flipEn    (flipEn),
    .quadEn    (quadEn),
    .nextPtr   (nextPtr),
    .doWrite   (doWrite),
    .outOfRange(outOfRange)
  );

  always_comb begin
    nextPhys = quadEn ? ROW_W'({nextPtr, 2'b00}) : nextPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      physRow  <= '0;
      repCount <= REP_W'(1);
      writeStb <= 1'b0;
      rangeErr <= 1'b0;
    end else if (strobe.rowStart) begin
      ptr      <= nextPtr;
      writeStb <= doWrite;
      rangeErr <= rangeErr | outOfRange;
      if (doWrite) begin
        physRow  <= nextPhys;
        repCount <= quadEn ? REP_W'(4) : REP_W'(1);
      end
    end else begin
      writeStb <= 1'b0;
    end
  end

endmodule

// File: rtl/rowAddrCtrl.sv
module rowAddrCtrl
  import rowPtrPkg::*;
#(
  parameter int ROWS   = 1600,
  parameter int CLKS   = 20,
  parameter int ADDR_W = 11,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataValid,
  input  logic [1:0]        rowMode,
  input  logic [ADDR_W-1:0] rowAddr,
  input  logic              flipEn,
  input  logic              quadEn,
  output logic [ROW_W-1:0]  physRow,
  output logic [2:0]        repCount,
  output logic              writeStb,
  output logic              rangeErr
);

  seqStrobe_t seqStrobe;

  rowCycleSeq #(
    .CLKS(CLKS)
  ) cycleSeq (
    .clk      (clk),
    .rstN     (rstN),
    .dataValid(dataValid),
    .strobe   (seqStrobe)
  );

  rowPtrPath #(
    .ROWS  (ROWS),
    .ADDR_W(ADDR_W),
    .ROW_W (ROW_W)
  ) ptrPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (seqStrobe),
    .rowMode (rowMode),
    .rowAddr (rowAddr),
    .flipEn  (flipEn),
    .quadEn  (quadEn),
    .physRow (physRow),
    .repCount(repCount),
    .writeStb(writeStb),
    .rangeErr(rangeErr)
  );

endmodule

// File: rtl/rowAddrCtrlChk.sv
module rowAddrCtrlChk #(
  parameter int ROWS  = 1600,
  parameter int CLKS  = 20,
  parameter int ROW_W = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             dataValid,
  input logic [ROW_W-1:0] physRow,
  input logic [2:0]       repCount,
  input logic             writeStb,
  input logic             rangeErr
);

  assert_strobe_framed_R2: assert property (@(posedge clk) disable iff (!rstN)
    writeStb |-> $past(dataValid));

  if (CLKS > 1) begin : gSinglePulse
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
      writeStb |=> !writeStb);
  end

  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |=> ($stable(physRow) && $stable(repCount)));

  assert_sticky_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    rangeErr |=> rangeErr);

  assert_no_write_on_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rangeErr) |-> !writeStb);

  assert_quad_align_R11: assert property (@(posedge clk) disable iff (!rstN)
    (writeStb && repCount == 3'd4) |-> (physRow[1:0] == 2'b00));

  assert_rep_legal_R11: assert property (@(posedge clk) disable iff (!rstN)
    (repCount == 3'd1) || (repCount == 3'd4));

  assert_in_array_R7: assert property (@(posedge clk) disable iff (!rstN)
    writeStb |-> (int'(physRow) <= ROWS - 1));

endmodule

bind rowAddrCtrl rowAddrCtrlChk #(
  .ROWS (ROWS),
  .CLKS (CLKS),
  .ROW_W(ROW_W)
) chkInst (.*);

// File: tb/tb_rowAddrCtrl.sv
module tb_rowAddrCtrl;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS   = 64;
  localparam int CLKS   = 4;
  localparam int ADDR_W = 11;
  localparam int ROW_W  = $clog2(ROWS);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              dataValid = 1'b0;
  logic [1:0]        rowMode = 2'b00;
  logic [ADDR_W-1:0] rowAddr = '0;
  logic              flipEn = 1'b0;
  logic              quadEn = 1'b0;
  logic [ROW_W-1:0]  physRow;
  logic [2:0]        repCount;
  logic              writeStb;
  logic              rangeErr;

  rowAddrCtrl #(.ROWS(ROWS), .CLKS(CLKS), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .dataValid(dataValid), .rowMode(rowMode),
    .rowAddr(rowAddr), .flipEn(flipEn), .quadEn(quadEn), .physRow(physRow),
    .repCount(repCount), .writeStb(writeStb), .rangeErr(rangeErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int vecs = 0;
  int bad  = 0;
  int mPtr = 0;
  int mPhys = 0;
  int mRep = 1;
  bit mErr = 1'b0;

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelRow(int mode, int addr, bit flip, bit quad, output bit wr);
    int last;
    int nxt;
    bit e;
    last = quad ? ROWS / 4 - 1 : ROWS - 1;
    nxt = mPtr;
    e = 1'b0;
    wr = 1'b0;
    case (mode)
      1: begin
        if (flip) begin
          if (mPtr == 0 || mPtr > last) e = 1'b1;
          else begin nxt = mPtr - 1; wr = 1'b1; end
        end else begin
          if (mPtr >= last) e = 1'b1;
          else begin nxt = mPtr + 1; wr = 1'b1; end
        end
      end
      2: begin
        if (addr > last) e = 1'b1;
        else begin nxt = addr; wr = 1'b1; end
      end
      3: begin nxt = flip ? last : 0; wr = 1'b1; end
      default: ;
    endcase
    mPtr = nxt;
    if (wr) begin
      mPhys = quad ? mPtr * 4 : mPtr;
      mRep  = quad ? 4 : 1;
    end
    mErr = mErr | e;
  endtask

  // Called at a negedge; returns at a negedge after CLKS valid clocks.
  task automatic doRow(string req, int mode, int addr, bit flip, bit quad, int gapPct);
    bit wr;
    dataValid = 1'b1;
    rowMode = 2'(mode);
    rowAddr = ADDR_W'(addr);
    flipEn = flip;
    quadEn = quad;
    @(negedge clk);
    modelRow(mode, addr, flip, quad, wr);
    chk({req, " writeStb"}, int'(writeStb), int'(wr));
    chk({req, " physRow"}, int'(physRow), mPhys);
    chk({req, " repCount"}, int'(repCount), mRep);
    chk({req, " rangeErr R10"}, int'(rangeErr), int'(mErr));
    for (int k = 1; k < CLKS; k++) begin
      if (int'($urandom % 100) < gapPct) begin
        dataValid = 1'b0;
        rowMode = 2'($urandom);
        rowAddr = ADDR_W'($urandom);
        for (int g = 0; g < 1 + int'($urandom % 3); g++) begin
          @(negedge clk);
          chk("R3 pause no strobe", int'(writeStb), 0);
          chk("R12 hold physRow", int'(physRow), mPhys);
        end
      end
      dataValid = 1'b1;
      rowMode = 2'($urandom);
      rowAddr = ADDR_W'($urandom);
      @(negedge clk);
      chk("R2 mid-cycle no strobe", int'(writeStb), 0);
      chk("R2 mid-cycle physRow", int'(physRow), mPhys);
    end
  endtask

  task automatic idle(int n);
    dataValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      rowMode = 2'($urandom);
      @(negedge clk);
      chk("R12 idle physRow", int'(physRow), mPhys);
      chk("R12 idle repCount", int'(repCount), mRep);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    dataValid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 physRow in reset", int'(physRow), 0);
    chk("R1 rangeErr in reset R10", int'(rangeErr), 0);
    rstN = 1'b1;
    mPtr = 0; mPhys = 0; mRep = 1; mErr = 1'b0;
    @(negedge clk);
    chk("R1 physRow", int'(physRow), 0);
    chk("R1 repCount", int'(repCount), 1);
    chk("R1 writeStb", int'(writeStb), 0);
    chk("R1 rangeErr", int'(rangeErr), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    doReset();

    doRow("R8 home up", 3, 0, 1'b0, 1'b0, 0);
    doRow("R5 step up", 1, 0, 1'b0, 1'b0, 50);
    doRow("R5 step up", 1, 0, 1'b0, 1'b0, 50);
    doRow("R5 step up", 1, 0, 1'b0, 1'b0, 0);
    chk("R5 pointer at 3", int'(physRow), 3);
    doRow("R4 idle", 0, 40, 1'b0, 1'b0, 30);
    chk("R4 physRow kept", int'(physRow), 3);
    idle(5);
    doRow("R7 load flipped", 2, 50, 1'b1, 1'b0, 0);
    chk("R7 physRow 50", int'(physRow), 50);
    doRow("R6 step down", 1, 0, 1'b1, 1'b0, 40);
    chk("R6 physRow 49", int'(physRow), 49);
    doRow("R8 home flipped", 3, 0, 1'b1, 1'b0, 0);
    chk("R8 physRow last", int'(physRow), ROWS - 1);
    doRow("R9 step past last", 1, 0, 1'b0, 1'b0, 0);
    chk("R9 flag set", int'(rangeErr), 1);
    doRow("R7 load over range", 2, ROWS, 1'b0, 1'b0, 0);
    doRow("R10 flag sticky idle", 0, 0, 1'b0, 1'b0, 0);
    doRow("R11 quad home flipped", 3, 0, 1'b1, 1'b1, 0);
    chk("R11 quad phys", int'(physRow), (ROWS / 4 - 1) * 4);
    chk("R11 quad rep", int'(repCount), 4);
    doRow("R11 quad step down", 1, 0, 1'b1, 1'b1, 0);
    chk("R11 quad phys step", int'(physRow), (ROWS / 4 - 2) * 4);
    doRow("R11 quad load over", 2, ROWS / 4, 1'b0, 1'b1, 0);
    doRow("R11 quad load edge", 2, ROWS / 4 - 1, 1'b0, 1'b1, 0);
    doRow("R11 quad step over", 1, 0, 1'b0, 1'b1, 0);

    doReset();
    chk("R10 reset clears flag", int'(rangeErr), 0);
    doRow("R7 load 0", 2, 0, 1'b1, 1'b0, 0);
    doRow("R9 step below 0", 1, 0, 1'b1, 1'b0, 0);
    chk("R9 below 0 flag", int'(rangeErr), 1);
    doRow("R9 physRow kept", 0, 0, 1'b1, 1'b0, 0);
    chk("R9 physRow 0", int'(physRow), 0);
    doReset();

    for (int n = 0; n < 600; n++) begin
      int r;
      int mode;
      int addr;
      bit flip;
      bit quad;
      r = int'($urandom % 10);
      mode = (r < 6) ? 1 : (r < 8) ? 2 : (r < 9) ? 0 : 3;
      addr = int'($urandom % (ROWS + 4));
      flip = ($urandom % 8) < 3;
      quad = ($urandom % 8) < 2;
      doRow("R2 random row", mode, addr, flip, quad, 20);
      if ($urandom % 6 == 0) idle(1 + int'($urandom % 3));
      if (n % 200 == 199) doReset();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule